// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch is taken. It combines two sources of information. The low bits of the branch address pick a row of a counter table. A global shift register holds the outcomes of the most recent resolved branches, and its value picks one counter inside that row. The selected saturating counter gives the prediction. A fetch stage presents a PC on the lookup port and receives the prediction combinationally in the same cycle.

When a branch resolves, the execute stage presents the branch PC and its real outcome on the update port. The block steps the one counter chosen by that PC and the current global history. It then shifts the outcome into the history. With `HIST_W` = 0 the history vanishes, and the block becomes a plain table of per-address counters. The table holds no address tags, so branches that share index bits also share counters.

Top module: `corr_bpred`

## Requirements
- R1: The row index is `pc[PC_LSB+IDX_W-1:PC_LSB]` (bits 5:2 by default). No tag is compared, so two PCs that differ only outside those bits read and write the same counters.
- R2: Each row holds 2^HIST_W counters. The counter used is at flat address `{row, history}`, with the history in the low bits. The lookup prediction is combinational from `lk_pc_i` in the same cycle.
- R3: A valid update changes only the counter selected by `up_pc_i` and the history present in that cycle. Every other counter keeps its value.
- R4: A counter increments on a taken outcome and decrements on a not-taken outcome. It saturates at 2^CTR_W-1 (11 for two bits) and at 0 (00).
- R5: The prediction is the counter MSB. Values 11 and 10 predict taken (1), and values 01 and 00 predict not-taken (0).
- R6: From a strong state, a single misprediction does not flip the prediction. Two consecutive mispredictions on the same counter do flip it.
- R7: On each valid update the history shifts left by one, and the outcome enters as the LSB (1 = taken). The history holds its value when no update is valid.
- R8: While `rst_ni` is low, and after it rises, every counter is at weakly not-taken (01, which is 2^(CTR_W-1)-1) and the history is zero.
- R9: When a lookup and an update select the same counter in one cycle, the lookup returns the value from before the update. It also uses the history from before the shift.
- R10: With `HIST_W` = 0 the block is a table of 2^IDX_W counters, indexed by PC bits alone, with no history influence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_pc_i | input | PC_W | PC of the branch being predicted |
| lk_taken_o | output | 1 | Prediction, 1 = taken |
| up_valid_i | input | 1 | A resolved branch is presented this cycle |
| up_pc_i | input | PC_W | PC of the resolved branch |
| up_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest states to reach from the ports are the ones where the history must return to a chosen value before the same counter is revisited. Examples are the second half of a two-miss flip, and an observation that a neighbouring history slot was left untouched. The stimulus steers the history with taken updates to an unrelated PC until it settles at all-ones. Only then does it touch the counter under test. Random traffic is also drawn from a handful of PCs plus aliased copies of them. This causes repeated collisions between lookups and updates on the same counter in the same cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;

  // weakly not-taken start value for an n-bit counter
  function automatic int unsigned ctr_init(int unsigned w);
    return (32'd1 << (w - 1)) - 32'd1;
  endfunction
endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int unsigned HIST_W = 2,
  localparam int unsigned HW = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          taken_i,
  output logic [HW-1:0] hist_o
);
  generate
    if (HIST_W == 0) begin : g_none
      logic unused_in;
      assign unused_in = clk_i ^ rst_ni ^ shift_i ^ taken_i;
      assign hist_o = '0;
    end else if (HIST_W == 1) begin : g_one
      logic hist_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= 1'b0;
        else if (shift_i) hist_q <= taken_i;
      end
      assign hist_o = hist_q;
    end else begin : g_many
      logic [HIST_W-1:0] hist_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], taken_i};
      end
      assign hist_o = hist_q;
    end
  endgenerate
endmodule

// File: rtl/bp_sat_ctr.sv
module bp_sat_ctr #(
  parameter int unsigned CTR_W = 2
) (
  input  logic             [CTR_W-1:0] old_i,
  input  bp_pkg::dir_e                 dir_i,
  output logic             [CTR_W-1:0] new_o
);
  localparam logic [CTR_W-1:0] CMax = '1;

  always_comb begin
    new_o = old_i;
    if (dir_i == bp_pkg::DIR_TAKEN) begin
      if (old_i != CMax) new_o = old_i + 1'b1;
    end else begin
      if (old_i != '0) new_o = old_i - 1'b1;
    end
  end
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTR_W  = 2,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CTR_W-1:0]  rd_ctr_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [CTR_W-1:0]  wr_old_o,
  input  logic              we_i,
  input  logic [CTR_W-1:0]  wr_data_i
);
  localparam logic [CTR_W-1:0] CInit = CTR_W'(bp_pkg::ctr_init(CTR_W));

  logic [CTR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CInit;
    end else if (we_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_ctr_o = mem_q[rd_addr_i];
  assign wr_old_o = mem_q[wr_addr_i];
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned PC_LSB = 2,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned HIST_W = 2,
  parameter int unsigned CTR_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_taken_o,
  input  logic            up_valid_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic            up_taken_i
);
  localparam int unsigned HW     = (HIST_W > 0) ? HIST_W : 1;
  localparam int unsigned ADDR_W = IDX_W + HIST_W;
  localparam int unsigned TOP_LO = PC_LSB + IDX_W;

  logic [HW-1:0]     hist;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [ADDR_W-1:0] lk_addr, up_addr;
  logic [CTR_W-1:0]  lk_ctr, up_old, up_new;
  bp_pkg::dir_e      up_dir;

  assign lk_idx = lk_pc_i[TOP_LO-1:PC_LSB];
  assign up_idx = up_pc_i[TOP_LO-1:PC_LSB];
  assign up_dir = up_taken_i ? bp_pkg::DIR_TAKEN : bp_pkg::DIR_NOT_TAKEN;

  logic unused_pc;
  assign unused_pc = ^{lk_pc_i[PC_W-1:TOP_LO], lk_pc_i[PC_LSB-1:0],
                       up_pc_i[PC_W-1:TOP_LO], up_pc_i[PC_LSB-1:0]};

  generate
    if (HIST_W == 0) begin : g_flat
      logic unused_hist;
      assign unused_hist = ^hist;
      assign lk_addr = lk_idx;
      assign up_addr = up_idx;
    end else begin : g_corr
      assign lk_addr = {lk_idx, hist};
      assign up_addr = {up_idx, hist};
    end
  endgenerate

  bp_ghist #(.HIST_W(HIST_W)) i_ghist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (up_valid_i),
    .taken_i (up_taken_i),
    .hist_o  (hist)
  );

  bp_ctr_table #(.ADDR_W(ADDR_W), .CTR_W(CTR_W)) i_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (lk_addr),
    .rd_ctr_o  (lk_ctr),
    .wr_addr_i (up_addr),
    .wr_old_o  (up_old),
    .we_i      (up_valid_i),
    .wr_data_i (up_new)
  );

  bp_sat_ctr #(.CTR_W(CTR_W)) i_sat (
    .old_i (up_old),
    .dir_i (up_dir),
    .new_o (up_new)
  );

  assign lk_taken_o = lk_ctr[CTR_W-1];
endmodule

// File: rtl/bp_chk.sv
module bp_chk #(
  parameter int unsigned HIST_W = 2,
  parameter int unsigned CTR_W  = 2,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned HW = (HIST_W > 0) ? HIST_W : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              up_valid_i,
  input logic              up_taken_i,
  input logic [HW-1:0]     hist_i,
  input logic [ADDR_W-1:0] up_addr_i,
  input logic [CTR_W-1:0]  up_old_i,
  input logic [CTR_W-1:0]  up_new_i
);
  localparam logic [CTR_W-1:0] CMax = '1;

  generate
    if (HIST_W > 0) begin : g_hist
      a_r7_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        up_valid_i |=> hist_i == HW'(($past(hist_i) << 1) | HW'($past(up_taken_i))));
      a_r7_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !up_valid_i |=> $stable(hist_i));
    end
  endgenerate

  a_r4_no_drop_on_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_taken_i) |-> up_new_i >= up_old_i);

  a_r4_no_rise_on_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !up_taken_i) |-> up_new_i <= up_old_i);

  a_r4_moves_unless_saturated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_old_i != CMax && up_old_i != '0) |-> up_new_i != up_old_i);

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && $past(up_valid_i) && $past(rst_ni) && up_addr_i == $past(up_addr_i))
      |-> up_old_i == $past(up_new_i));
endmodule

bind corr_bpred bp_chk #(
  .HIST_W (HIST_W),
  .CTR_W  (CTR_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .up_valid_i (up_valid_i),
  .up_taken_i (up_taken_i),
  .hist_i     (hist),
  .up_addr_i  (up_addr),
  .up_old_i   (up_old),
  .up_new_i   (up_new)
);

// File: tb/test_corr_bpred.sv
module test_corr_bpred;
  localparam int PC_LSB = 2;
  localparam int IDX_W  = 4;
  localparam int NROW   = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic        lk_t2, lk_t0;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  int ref2 [NROW*4];
  int ref0 [NROW];
  int ref_h;

  always #2 clk = ~clk;

  corr_bpred i_corr_bpred (
    .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc), .lk_taken_o(lk_t2),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_taken_i(up_taken));

  corr_bpred #(.HIST_W(0)) i_corr_bpred_m0 (
    .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc), .lk_taken_o(lk_t0),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_taken_i(up_taken));

  function automatic int row(logic [31:0] pc);
    return int'(pc[PC_LSB +: IDX_W]);
  endfunction

  function automatic int sat(int c, bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NROW*4; i++) ref2[i] = 1;
    for (int i = 0; i < NROW; i++) ref0[i] = 1;
    ref_h = 0;
  endtask

  task automatic check(logic act, logic exp, string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(logic [31:0] lpc, bit uv, logic [31:0] upc, bit ut, string tag);
    int a;
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    check(lk_t2, ref2[row(lpc)*4 + ref_h] >= 2, tag);
    check(lk_t0, ref0[row(lpc)] >= 2, {tag, " R10"});
    if (uv) begin
      a = row(upc)*4 + ref_h;
      ref2[a] = sat(ref2[a], ut);
      ref0[row(upc)] = sat(ref0[row(upc)], ut);
      ref_h = ((ref_h << 1) | int'(ut)) & 3;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    up_valid = 1'b0;
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    for (int i = 0; i < NROW; i++) begin
      lk_pc = 32'(i << PC_LSB);
      #1;
      check(lk_t2, 1'b0, "R8 during reset");
    end
    rst_n = 1'b1;
  endtask

  localparam logic [31:0] PcX  = 32'h0000_0004;
  localparam logic [31:0] PcA  = 32'h0000_0014;
  localparam logic [31:0] PcAa = 32'h0000_0054;
  localparam logic [31:0] PcB  = 32'h0000_0020;

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();
    for (int i = 0; i < NROW; i++) step(32'(i << PC_LSB), 0, '0, 0, "R8 after reset");

    step(PcX, 1, PcX, 1, "R7 steer");
    step(PcX, 1, PcX, 1, "R7 steer");
    step(PcA, 1, PcA, 1, "R4 inc");
    step(PcA, 1, PcA, 1, "R5 weak taken");
    step(PcA, 1, PcA, 1, "R4 sat high");
    step(PcAa, 0, '0, 0, "R1 alias");
    step(PcA, 1, PcA, 0, "R9 same cycle");
    step(PcA, 0, '0, 0, "R2 history select");
    step(PcX, 1, PcX, 1, "R3 other slot");
    step(PcX, 1, PcX, 1, "R3 other slot");
    step(PcA, 0, '0, 0, "R6 one miss");
    step(PcA, 1, PcA, 0, "R6 second miss");
    step(PcX, 1, PcX, 1, "R7 steer");
    step(PcX, 1, PcX, 1, "R7 steer");
    step(PcA, 0, '0, 0, "R6 flipped");
    for (int i = 0; i < 6; i++) step(PcB, 1, PcB, 0, "R4 sat low");
    step(PcB, 0, '0, 0, "R7 hold");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] lp, upc;
      lp  = 32'({$urandom_range(3, 0), 2'b00, $urandom_range(3, 0), 2'b00});
      upc = ($urandom_range(3, 0) == 0) ? lp
          : 32'({$urandom_range(3, 0), 2'b00, $urandom_range(3, 0), 2'b00});
      step(lp, $urandom_range(3, 0) != 0, upc, $urandom_range(2, 0) != 0,
           "R3 R4 R7 random");
      if (n == 2000) begin
        do_reset();
        step(PcA, 0, '0, 0, "R8 re-reset");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule